// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Sticky Flags

This block multiplies two signed 16-bit operands and adds the 32-bit product into a 42-bit accumulator, kept as a 10-bit upper part and a 32-bit lower part. It runs in one of two arithmetic modes. In wrapping mode the sum wraps across all 42 bits. In clamping mode the sum is limited to the signed 32-bit range, and the upper part holds the sign extension of the lower part. The block keeps its own negative, zero and overflow flags, which the processor's condition codes cannot see until a store command copies them out. The overflow flag is sticky.

The block also generates addresses. It holds a small file of pointer registers. Each accumulate names two of them, sends both addresses to an external memory, and post-increments the pointers. Software can write any pointer directly when the block is idle. An accumulate keeps the block busy for four cycles. A change of mode that arrives too soon after an accumulate is issued is refused and reported.

Top module: `mac_unit`

## Requirements
- R1: A command is accepted only while `busy_o` is low. An accepted accumulate (`cmd_op_i`=00) holds `busy_o` high for exactly 4 cycles. The signed product `op_a_i*op_b_i` appears in `acc_o` from the 4th busy cycle onward. A command presented while busy has no effect. After reset, `busy_o`, `acc_o`, `ccr_o`, `mode_sat_o`, `mode_err_o` and `rd_req_o` are all 0.
- R2: In wrapping mode (`mode_sat_o`=0) the accumulator wraps modulo 2^42. If the true signed 42-bit sum falls outside the signed 42-bit range, the overflow flag is set.
- R3: In clamping mode (`mode_sat_o`=1) the new value is the signed sum of the low 32 accumulator bits and the product. A sum above 0x7FFFFFFF is clamped to 0x7FFFFFFF, and a sum below -0x80000000 is clamped to -0x80000000; either clamp sets the overflow flag. Bits 41:32 receive the sign extension of bit 31.
- R4: After an accumulate, the negative flag equals accumulator bit 31 in clamping mode and bit 41 in wrapping mode.
- R5: After an accumulate, the zero flag is 1 exactly when the low 32 bits are zero (clamping mode) or all 42 bits are zero (wrapping mode).
- R6: Once set, the overflow flag stays set until a clear (`cmd_op_i`=01) or load (`cmd_op_i`=10) command, both of which reset it to 0.
- R7: Only an accumulate changes the negative and zero flags. Clear, load and store leave them unchanged.
- R8: `ccr_o` changes only on a store command (`cmd_op_i`=11), which copies {negative, zero, overflow} into bits [2:0] in that order.
- R9: When the two selected pointers differ, `addr_a_o` and `addr_b_o` take their values in the cycle after acceptance, with `rd_req_o` high for that one cycle. Each of the two pointers then advances by 2.
- R10: When both selects name the same pointer holding P, the addresses are P and P+2 and the pointer ends at P+4.
- R11: A write to `mode_sat_i` takes effect only at a clock edge that is 3 or more edges after the edge that accepted the last accumulate. An earlier write is dropped, and `mode_err_o` goes high for one cycle.
- R12: A clear sets the accumulator to 0. A load sets it to `load_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_op_i | input | 2 | 00 accumulate, 01 clear, 10 load, 11 store |
| ptr_a_sel_i | input | 3 | Pointer for first operand |
| ptr_b_sel_i | input | 3 | Pointer for second operand |
| load_data_i | input | 42 | Accumulator value for load |
| mode_we_i | input | 1 | Mode write request |
| mode_sat_i | input | 1 | Requested mode, 1 = clamping |
| ptr_we_i | input | 1 | Pointer write enable |
| ptr_wsel_i | input | 3 | Pointer to write |
| ptr_wdata_i | input | 24 | Pointer write value |
| rd_req_o | output | 1 | Operand fetch request |
| addr_a_o | output | 24 | First operand address |
| addr_b_o | output | 24 | Second operand address |
| op_a_i | input | 16 | First operand, sampled the cycle after `rd_req_o` |
| op_b_i | input | 16 | Second operand, sampled the cycle after `rd_req_o` |
| busy_o | output | 1 | Accumulate in progress |
| mode_sat_o | output | 1 | Current mode |
| mode_err_o | output | 1 | Early mode write refused |
| acc_o | output | 42 | Accumulator {upper, lower} |
| ccr_o | output | 3 | Stored flags {N, Z, V} |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- **Wrap versus clamp.** Sums are driven past both the 42-bit and the 32-bit limits, in both directions. A design that clamped in the wrong mode, or wrapped at the wrong width, would show a wrong `acc_o` and a wrong overflow bit.
- **Mode-dependent flag bits.** Accumulator values are chosen so that bit 31 differs from bit 41, and so that the low word is zero while the upper part is not. A design that took the negative or zero flag from the wrong width would be caught.
- **Same pointer selected twice.** This case is run and followed by a second access through that pointer. It catches a pointer that advanced by only 2, or that was handed out twice.
- **Command and mode timing.** Mode writes are placed one, two and three edges after an accumulate is issued, and clears are placed inside a busy window. This catches a guard that is off by one, and any command that is accepted while busy.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    CMD_ACC   = 2'b00,
    CMD_CLR   = 2'b01,
    CMD_LOAD  = 2'b10,
    CMD_STORE = 2'b11
  } mac_cmd_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
  } mac_flags_t;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
#(
  parameter int LAT      = 4,
  parameter int MODE_GAP = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_op_i,
  input  logic       mode_we_i,
  input  logic       mode_sat_i,
  output logic       busy_o,
  output logic       issue_acc_o,
  output logic       fire_clr_o,
  output logic       fire_load_o,
  output logic       fire_store_o,
  output logic       fetch_o,
  output logic       capture_o,
  output logic       commit_o,
  output logic       mode_sat_o,
  output logic       mode_err_o
);
  localparam int SW = $clog2(LAT + 1);
  localparam int GW = $clog2(MODE_GAP + 1);

  logic [SW-1:0] stage_q;
  logic [GW-1:0] gap_q;
  logic          mode_q, err_q, accept, mode_ok;

  assign busy_o       = (stage_q != '0);
  assign accept       = cmd_valid_i && !busy_o;
  assign issue_acc_o  = accept && (cmd_op_i == CMD_ACC);
  assign fire_clr_o   = accept && (cmd_op_i == CMD_CLR);
  assign fire_load_o  = accept && (cmd_op_i == CMD_LOAD);
  assign fire_store_o = accept && (cmd_op_i == CMD_STORE);
  assign fetch_o      = (stage_q == SW'(1));
  assign capture_o    = (stage_q == SW'(LAT - 2));
  assign commit_o     = (stage_q == SW'(LAT - 1));
  assign mode_ok      = (gap_q >= GW'(MODE_GAP)) && !issue_acc_o;
  assign mode_sat_o   = mode_q;
  assign mode_err_o   = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else if (issue_acc_o) begin
      stage_q <= SW'(1);
    end else if (busy_o) begin
      stage_q <= (stage_q == SW'(LAT)) ? '0 : stage_q + SW'(1);
    end
  end

  // edges elapsed since the last accepted accumulate, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= GW'(MODE_GAP);
    end else if (issue_acc_o) begin
      gap_q <= GW'(1);
    end else if (gap_q < GW'(MODE_GAP)) begin
      gap_q <= gap_q + GW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= mode_we_i && !mode_ok;
      if (mode_we_i && mode_ok) mode_q <= mode_sat_i;
    end
  end

  a_r1_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && stage_q != SW'(LAT)) |=> busy_o);
  a_r1_busy_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_q == SW'(LAT)) |=> !busy_o);
  a_r11_mode_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_i && gap_q < GW'(MODE_GAP)) |=> ($stable(mode_q) && mode_err_o));
endmodule

// File: rtl/mac_ptr.sv
module mac_ptr #(
  parameter int AW   = 24,
  parameter int NPTR = 8,
  parameter int STEP = 2,
  localparam int PSW = $clog2(NPTR)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           issue_i,
  input  logic [PSW-1:0] sel_a_i,
  input  logic [PSW-1:0] sel_b_i,
  input  logic           we_i,
  input  logic [PSW-1:0] wsel_i,
  input  logic [AW-1:0]  wdata_i,
  output logic [AW-1:0]  addr_a_o,
  output logic [AW-1:0]  addr_b_o
);
  logic [AW-1:0] ptr_q [NPTR];
  logic          same;

  assign same = (sel_a_i == sel_b_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_a_o <= '0;
      addr_b_o <= '0;
    end else if (issue_i) begin
      addr_a_o <= ptr_q[sel_a_i];
      addr_b_o <= same ? ptr_q[sel_a_i] + AW'(STEP) : ptr_q[sel_b_i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NPTR; i++) ptr_q[i] <= '0;
    end else begin
      for (int i = 0; i < NPTR; i++) begin
        if (issue_i && same && sel_a_i == PSW'(i))
          ptr_q[i] <= ptr_q[i] + AW'(2 * STEP);
        else if (issue_i && (sel_a_i == PSW'(i) || sel_b_i == PSW'(i)))
          ptr_q[i] <= ptr_q[i] + AW'(STEP);
        else if (we_i && wsel_i == PSW'(i))
          ptr_q[i] <= wdata_i;
      end
    end
  end

  a_r10_same_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && same) |=> (addr_b_o == addr_a_o + AW'(STEP)));
  a_r9_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> ($stable(addr_a_o) && $stable(addr_b_o)));
endmodule

// File: rtl/mac_dp.sv
module mac_dp
  import mac_pkg::*;
#(
  parameter int OP_W = 16,
  parameter int HI_W = 10,
  parameter int LO_W = 32,
  localparam int ACC_W = HI_W + LO_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic             commit_i,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             store_i,
  input  logic             mode_sat_i,
  input  logic [OP_W-1:0]  op_a_i,
  input  logic [OP_W-1:0]  op_b_i,
  input  logic [ACC_W-1:0] load_data_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [2:0]       ccr_o
);
  localparam int PW = 2 * OP_W;

  logic signed [PW-1:0] prod_q;
  logic [ACC_W-1:0]     acc_q, prod_x, sum_ns, sat_acc, nxt_acc;
  logic [LO_W:0]        s_sat;
  logic [LO_W-1:0]      lo_res;
  logic                 ovf_ns, ovf_s, nxt_ovf, nxt_n, nxt_z;
  logic                 n_q, z_q, v_q;
  mac_flags_t           ccr_q;

  always_comb begin
    prod_x  = {{(ACC_W-PW){prod_q[PW-1]}}, prod_q};
    sum_ns  = acc_q + prod_x;
    ovf_ns  = (acc_q[ACC_W-1] == prod_x[ACC_W-1]) && (sum_ns[ACC_W-1] != acc_q[ACC_W-1]);
    s_sat   = {acc_q[LO_W-1], acc_q[LO_W-1:0]} + prod_x[LO_W:0];
    ovf_s   = s_sat[LO_W] ^ s_sat[LO_W-1];
    if (!ovf_s)           lo_res = s_sat[LO_W-1:0];
    else if (s_sat[LO_W]) lo_res = {1'b1, {(LO_W-1){1'b0}}};
    else                  lo_res = {1'b0, {(LO_W-1){1'b1}}};
    sat_acc = {{HI_W{lo_res[LO_W-1]}}, lo_res};
    nxt_acc = mode_sat_i ? sat_acc : sum_ns;
    nxt_ovf = mode_sat_i ? ovf_s : ovf_ns;
    nxt_n   = mode_sat_i ? nxt_acc[LO_W-1] : nxt_acc[ACC_W-1];
    nxt_z   = mode_sat_i ? ~|nxt_acc[LO_W-1:0] : ~|nxt_acc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prod_q <= '0;
    else if (capture_i) prod_q <= $signed(op_a_i) * $signed(op_b_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      n_q   <= 1'b0;
      z_q   <= 1'b0;
      v_q   <= 1'b0;
    end else if (commit_i) begin
      acc_q <= nxt_acc;
      n_q   <= nxt_n;
      z_q   <= nxt_z;
      v_q   <= v_q | nxt_ovf;
    end else if (clr_i) begin
      acc_q <= '0;
      v_q   <= 1'b0;
    end else if (load_i) begin
      acc_q <= load_data_i;
      v_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ccr_q <= '0;
    else if (store_i) ccr_q <= '{n: n_q, z: z_q, v: v_q};
  end

  assign acc_o = acc_q;
  assign ccr_o = ccr_q;

  a_r6_v_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && !clr_i && !load_i) |=> v_q);
  a_r7_nz_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> ($stable(n_q) && $stable(z_q)));
  a_r8_ccr_store_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !store_i |=> $stable(ccr_o));
  a_r3_sat_sext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && mode_sat_i) |=> ((&acc_q[ACC_W-1:LO_W-1]) || !(|acc_q[ACC_W-1:LO_W-1])));
  a_r5_zero_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !mode_sat_i) |=> (z_q == (acc_q == '0)));
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int OP_W     = 16,
  parameter int HI_W     = 10,
  parameter int LO_W     = 32,
  parameter int AW       = 24,
  parameter int NPTR     = 8,
  parameter int STEP     = 2,
  parameter int LAT      = 4,
  parameter int MODE_GAP = 3,
  localparam int ACC_W   = HI_W + LO_W,
  localparam int PSW     = $clog2(NPTR)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic [PSW-1:0]   ptr_a_sel_i,
  input  logic [PSW-1:0]   ptr_b_sel_i,
  input  logic [ACC_W-1:0] load_data_i,
  input  logic             mode_we_i,
  input  logic             mode_sat_i,
  input  logic             ptr_we_i,
  input  logic [PSW-1:0]   ptr_wsel_i,
  input  logic [AW-1:0]    ptr_wdata_i,
  output logic             rd_req_o,
  output logic [AW-1:0]    addr_a_o,
  output logic [AW-1:0]    addr_b_o,
  input  logic [OP_W-1:0]  op_a_i,
  input  logic [OP_W-1:0]  op_b_i,
  output logic             busy_o,
  output logic             mode_sat_o,
  output logic             mode_err_o,
  output logic [ACC_W-1:0] acc_o,
  output logic [2:0]       ccr_o
);
  logic issue_acc, fire_clr, fire_load, fire_store, capture, commit;

  mac_ctrl #(.LAT(LAT), .MODE_GAP(MODE_GAP)) ctrl_i (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .mode_we_i, .mode_sat_i,
    .busy_o, .issue_acc_o(issue_acc), .fire_clr_o(fire_clr),
    .fire_load_o(fire_load), .fire_store_o(fire_store), .fetch_o(rd_req_o),
    .capture_o(capture), .commit_o(commit), .mode_sat_o, .mode_err_o
  );

  mac_ptr #(.AW(AW), .NPTR(NPTR), .STEP(STEP)) ptr_i (
    .clk_i, .rst_ni, .issue_i(issue_acc), .sel_a_i(ptr_a_sel_i),
    .sel_b_i(ptr_b_sel_i), .we_i(ptr_we_i), .wsel_i(ptr_wsel_i),
    .wdata_i(ptr_wdata_i), .addr_a_o, .addr_b_o
  );

  mac_dp #(.OP_W(OP_W), .HI_W(HI_W), .LO_W(LO_W)) dp_i (
    .clk_i, .rst_ni, .capture_i(capture), .commit_i(commit),
    .clr_i(fire_clr), .load_i(fire_load), .store_i(fire_store),
    .mode_sat_i(mode_sat_o), .op_a_i, .op_b_i, .load_data_i, .acc_o, .ccr_o
  );
endmodule

// File: tb/mac_unit_tb_top.sv
module mac_unit_tb_top;
  localparam int NPTR = 8;

  logic        clk = 1'b0;
  logic        rst_ni, cmd_valid_i, mode_we_i, mode_sat_i, ptr_we_i;
  logic [1:0]  cmd_op_i;
  logic [2:0]  ptr_a_sel_i, ptr_b_sel_i, ptr_wsel_i;
  logic [41:0] load_data_i, acc_o;
  logic [23:0] ptr_wdata_i, addr_a_o, addr_b_o;
  logic [15:0] op_a_i, op_b_i, fa, fb;
  logic        rd_req_o, busy_o, mode_sat_o, mode_err_o, use_force;
  logic [2:0]  ccr_o;

  int checks = 0, errors = 0;
  logic [41:0] m_acc;
  logic        m_n, m_z, m_v, m_sat;
  logic [23:0] m_ptr [NPTR];

  always #2 clk = ~clk;

  function automatic logic [15:0] memf(input logic [23:0] a);
    return (a[15:0] * 16'h9e37) ^ {a[23:16], a[23:16]};
  endfunction

  assign op_a_i = use_force ? fa : memf(addr_a_o);
  assign op_b_i = use_force ? fb : memf(addr_b_o);

  mac_unit dut_i (
    .clk_i(clk), .rst_ni, .cmd_valid_i, .cmd_op_i, .ptr_a_sel_i, .ptr_b_sel_i,
    .load_data_i, .mode_we_i, .mode_sat_i, .ptr_we_i, .ptr_wsel_i, .ptr_wdata_i,
    .rd_req_o, .addr_a_o, .addr_b_o, .op_a_i, .op_b_i, .busy_o, .mode_sat_o,
    .mode_err_o, .acc_o, .ccr_o
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic model_acc(input logic [15:0] a, input logic [15:0] b);
    longint sa, sb, p, x, s, lim;
    logic ov;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    p  = sa * sb;
    ov = 1'b0;
    if (m_sat) begin
      lim = 64'sd2147483647;
      x = longint'($signed(m_acc[31:0]));
      s = x + p;
      if (s > lim) begin s = lim; ov = 1'b1; end
      else if (s < -lim - 1) begin s = -lim - 1; ov = 1'b1; end
      m_acc = s[41:0];
      m_n = m_acc[31];
      m_z = (m_acc[31:0] == 32'd0);
    end else begin
      lim = (64'sd1 <<< 41) - 1;
      x = longint'($signed(m_acc));
      s = x + p;
      ov = (s > lim) || (s < -lim - 1);
      m_acc = s[41:0];
      m_n = m_acc[41];
      m_z = (m_acc == 42'd0);
    end
    m_v = m_v | ov;
  endtask

  // mode_at: edge index after issue carrying a mode write (0 = none)
  task automatic do_acc(input int sa, input int sb, input bit poke_clr,
                        input int mode_at, input bit mode_val);
    logic [23:0] ea, eb;
    logic [15:0] va, vb;
    int busy_cnt;
    ea = m_ptr[sa];
    eb = (sa == sb) ? m_ptr[sa] + 24'd2 : m_ptr[sb];
    if (sa == sb) m_ptr[sa] = m_ptr[sa] + 24'd4;
    else begin
      m_ptr[sa] = m_ptr[sa] + 24'd2;
      m_ptr[sb] = m_ptr[sb] + 24'd2;
    end
    va = use_force ? fa : memf(ea);
    vb = use_force ? fb : memf(eb);
    cmd_valid_i = 1'b1;
    cmd_op_i = 2'b00;
    ptr_a_sel_i = 3'(sa);
    ptr_b_sel_i = 3'(sb);
    tick();
    cmd_valid_i = 1'b0;
    busy_cnt = busy_o ? 1 : 0;
    chk("R9", "rd_req", 64'(rd_req_o), 64'd1);
    chk((sa == sb) ? "R10" : "R9", "addr_a", 64'(addr_a_o), 64'(ea));
    chk((sa == sb) ? "R10" : "R9", "addr_b", 64'(addr_b_o), 64'(eb));
    for (int k = 1; k <= 4; k++) begin
      if (poke_clr && k == 1) begin
        cmd_valid_i = 1'b1;
        cmd_op_i = 2'b01;
      end
      if (mode_at == k) begin
        mode_we_i = 1'b1;
        mode_sat_i = mode_val;
      end
      tick();
      cmd_valid_i = 1'b0;
      mode_we_i = 1'b0;
      if (k < 4 && busy_o) busy_cnt++;
      if (k == 3) begin
        model_acc(va, vb);
        chk(poke_clr ? "R1 busy-ignore" : (m_sat ? "R3" : "R2"), "acc", 64'(acc_o), 64'(m_acc));
      end
      if (mode_at == k) begin
        chk("R11", "mode_err", 64'(mode_err_o), (k >= 3) ? 64'd0 : 64'd1);
        if (k >= 3) m_sat = mode_val;
        chk("R11", "mode", 64'(mode_sat_o), 64'(m_sat));
      end
    end
    chk("R1", "busy_end", 64'(busy_o), 64'd0);
    chk("R1", "busy_len", 64'(busy_cnt), 64'd4);
  endtask

  task automatic do_store();
    cmd_valid_i = 1'b1;
    cmd_op_i = 2'b11;
    tick();
    cmd_valid_i = 1'b0;
    chk("R8", "ccr", 64'(ccr_o), 64'({m_n, m_z, m_v}));
    chk("R7", "acc_after_store", 64'(acc_o), 64'(m_acc));
  endtask

  task automatic do_load(input logic [41:0] d);
    cmd_valid_i = 1'b1;
    cmd_op_i = 2'b10;
    load_data_i = d;
    tick();
    cmd_valid_i = 1'b0;
    m_acc = d;
    m_v = 1'b0;
    chk("R12", "load", 64'(acc_o), 64'(m_acc));
  endtask

  task automatic do_clear();
    cmd_valid_i = 1'b1;
    cmd_op_i = 2'b01;
    tick();
    cmd_valid_i = 1'b0;
    m_acc = '0;
    m_v = 1'b0;
    chk("R12", "clear", 64'(acc_o), 64'd0);
  endtask

  task automatic set_mode(input bit v);
    mode_we_i = 1'b1;
    mode_sat_i = v;
    tick();
    mode_we_i = 1'b0;
    m_sat = v;
    chk("R11", "idle_mode", 64'(mode_sat_o), 64'(v));
    chk("R11", "idle_err", 64'(mode_err_o), 64'd0);
  endtask

  task automatic go(input logic [15:0] a, input logic [15:0] b);
    use_force = 1'b1;
    fa = a;
    fb = b;
    do_acc(0, 1, 1'b0, 0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    logic [2:0] keep;
    void'($urandom(32'd20240611));
    rst_ni = 1'b0;
    cmd_valid_i = 1'b0; cmd_op_i = '0; ptr_a_sel_i = '0; ptr_b_sel_i = '0;
    load_data_i = '0; mode_we_i = 1'b0; mode_sat_i = 1'b0; ptr_we_i = 1'b0;
    ptr_wsel_i = '0; ptr_wdata_i = '0; use_force = 1'b0; fa = '0; fb = '0;
    m_acc = '0; m_n = 0; m_z = 0; m_v = 0; m_sat = 0;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    chk("R1", "rst_busy", 64'(busy_o), 64'd0);
    chk("R1", "rst_acc", 64'(acc_o), 64'd0);
    chk("R1", "rst_ccr", 64'(ccr_o), 64'd0);
    chk("R1", "rst_mode", 64'(mode_sat_o), 64'd0);
    chk("R1", "rst_err", 64'(mode_err_o), 64'd0);
    chk("R1", "rst_req", 64'(rd_req_o), 64'd0);

    for (int i = 0; i < NPTR; i++) begin
      m_ptr[i] = 24'($urandom) & 24'hFFFFFE;
      ptr_we_i = 1'b1; ptr_wsel_i = 3'(i); ptr_wdata_i = m_ptr[i];
      tick();
    end
    ptr_we_i = 1'b0;

    // basic product, then flags reach ccr only via store
    go(16'd3, 16'hFFFB);
    chk("R8", "ccr_before_store", 64'(ccr_o), 64'd0);
    do_store();
    chk("R4", "neg_small", 64'(ccr_o[2]), 64'd1);

    // same pointer twice, then reuse it
    use_force = 1'b0;
    do_acc(3, 3, 1'b0, 0, 1'b0);
    do_acc(3, 4, 1'b0, 0, 1'b0);
    do_acc(5, 2, 1'b0, 0, 1'b0);

    // 42-bit wrap
    do_load(42'h1FF_FFFF_FFFF);
    go(16'h4000, 16'h4000);
    do_store();
    chk("R2", "wrap_v", 64'(ccr_o[0]), 64'd1);
    chk("R4", "wrap_n41", 64'(ccr_o[2]), 64'd1);
    // sticky
    go(16'd1, 16'd1);
    do_store();
    chk("R6", "v_sticky", 64'(ccr_o[0]), 64'd1);
    keep = ccr_o;
    do_load(42'h0);
    do_store();
    chk("R7", "nz_after_load", 64'(ccr_o[2:1]), 64'(keep[2:1]));
    chk("R6", "v_cleared_load", 64'(ccr_o[0]), 64'd0);
    go(16'h7FFF, 16'h7FFF);
    do_clear();
    do_store();
    chk("R7", "nz_after_clear", 64'(ccr_o[2:1]), 64'b00);

    // zero and negative flag width in wrapping mode
    do_load({10'h001, 32'h0});
    go(16'd0, 16'd5);
    do_store();
    chk("R5", "z_wide", 64'(ccr_o[1]), 64'd0);
    do_load(42'h0);
    go(16'd0, 16'd5);
    do_store();
    chk("R5", "z_set", 64'(ccr_o[1]), 64'd1);
    do_load({10'h000, 32'h8000_0000});
    go(16'd0, 16'd1);
    do_store();
    chk("R4", "n_bit41", 64'(ccr_o[2]), 64'd0);

    // clamping mode
    set_mode(1'b1);
    do_load({10'h000, 32'h8000_0000});
    go(16'd0, 16'd1);
    do_store();
    chk("R4", "n_bit31", 64'(ccr_o[2]), 64'd1);
    chk("R3", "sext_hi", 64'(acc_o[41:32]), 64'h3FF);
    do_load({10'h155, 32'h0000_0000});
    go(16'd0, 16'd1);
    do_store();
    chk("R5", "z_low32", 64'(ccr_o[1]), 64'd1);
    do_load(42'h0_7FFF_FFF0);
    go(16'h4000, 16'h4000);
    do_store();
    chk("R3", "clamp_max", 64'(acc_o), 64'h0_7FFF_FFFF);
    chk("R3", "clamp_v", 64'(ccr_o[0]), 64'd1);
    do_load(42'h0_8000_0010);
    go(16'h4000, 16'hC000);
    do_store();
    chk("R3", "clamp_min", 64'(acc_o), 64'h3FF_8000_0000);

    // command while busy ignored
    do_load(42'h0_0000_1000);
    use_force = 1'b1; fa = 16'd2; fb = 16'd2;
    do_acc(6, 7, 1'b1, 0, 1'b0);

    // mode write timing
    set_mode(1'b0);
    do_acc(1, 2, 1'b0, 1, 1'b1);
    do_acc(1, 2, 1'b0, 2, 1'b1);
    do_acc(1, 2, 1'b0, 3, 1'b1);
    do_acc(1, 2, 1'b0, 3, 1'b0);

    // random mix
    for (int it = 0; it < 250; it++) begin
      int sa, sb, ma;
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0) do_store();
      else if (r == 1) do_load({$urandom, $urandom} & 42'h3FF_FFFF_FFFF);
      else if (r == 2) do_clear();
      sa = int'($urandom_range(0, NPTR - 1));
      sb = ($urandom_range(0, 5) == 0) ? sa : int'($urandom_range(0, NPTR - 1));
      ma = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 4)) : 0;
      use_force = ($urandom_range(0, 3) == 0);
      fa = 16'($urandom);
      fb = 16'($urandom);
      do_acc(sa, sb, 1'b0, ma, 1'($urandom));
    end
    do_store();

    report();
    $finish;
  end
endmodule